// File: doc/BRIEF.md
# UART Byte FIFO Pair with Receive Trigger Control

This block keeps the receive and transmit byte queues of a UART and the write-only control register that governs them. The receive shifter pushes bytes into the receive queue and software drains them. Software fills the transmit queue and the transmit shifter drains it. Each queue reports its fill level, empty and full flags, and a sticky overrun flag. The receive side also raises a data-available request once enough characters have built up.

A control write carries a master enable in bit 0. Flush requests for each queue and a two-bit receive threshold selector are accepted only in a write that also sets bit 0. Any change of the enable state empties both queues. The flush bits act once and are not stored, so later writes do not repeat them.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset both queues are empty (level 0, empty 1, full 0), overrun flags are 0, the block is disabled (`fifo_en` 0), the threshold code is 00 and `rx_req` is 0.
- R2: On each control write, `fifo_en` takes the value of `cfg_wdata[0]`. The queues accept pushes and pops from the next cycle on.
- R3: A control write whose bit 0 differs from the current enable state empties both queues and clears both overrun flags at that clock edge.
- R4: A control write with bits 0 and 1 both set empties only the receive queue. The transmit queue is untouched, and a later write without bit 1 does not empty it again.
- R5: A control write with bits 0 and 2 both set empties only the transmit queue. The receive queue is untouched, and a later write without bit 2 does not empty it again.
- R6: Bits [7:6] of a write with bit 0 set select the receive threshold: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14 characters. `rx_req` is 1 exactly while enabled and the receive level is at or above the threshold.
- R7: Bits [5:3] of a control write have no effect on levels, contents or the request.
- R8: Each queue holds 16 bytes first in, first out. A pop loads the oldest byte into the data output at that edge. A push and a pop in the same cycle keep the level unchanged.
- R9: A push to a full queue without a pop in the same cycle is dropped, the stored bytes are kept, and the overrun flag sets and stays set until that queue is emptied by a flush.
- R10: A pop from an empty queue leaves the data output and the level unchanged.
- R11: While disabled, pushes and pops are ignored and both levels stay 0.
- R12: When a flush and a push to the same queue fall in the same cycle, the flush wins and the byte is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| fifo_en | output | 1 | Current enable state |
| rx_push | input | 1 | Receive queue push |
| rx_din | input | 8 | Receive push data |
| rx_pop | input | 1 | Receive queue pop |
| rx_dout | output | 8 | Last byte popped from receive queue |
| rx_level | output | 5 | Receive fill level |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| rx_req | output | 1 | Receive threshold reached |
| tx_push | input | 1 | Transmit queue push |
| tx_din | input | 8 | Transmit push data |
| tx_pop | input | 1 | Transmit queue pop |
| tx_dout | output | 8 | Last byte popped from transmit queue |
| tx_level | output | 5 | Transmit fill level |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_overrun | output | 1 | Sticky transmit overrun flag |

## Verification
The bench builds the block with its defaults: 16 entries of 8 bits and thresholds of 1, 4, 8 and 14. A depth of 16 keeps the full boundary and the overrun path a few pushes away. It also drives the power-of-two pointer wrap. The threshold of 14 sits just below full, so all four threshold codes can be stepped through on one growing queue without flushing it between steps.

// File: rtl/uftc_pkg.sv
package uftc_pkg;
   localparam int CFG_W     = 8;
   localparam int BIT_EN    = 0;
   localparam int BIT_CLRRX = 1;
   localparam int BIT_CLRTX = 2;
   localparam int TRIG_LSB  = 6;

   typedef struct packed {
      logic       enable;
      logic       clr_rx;
      logic       clr_tx;
      logic [1:0] trig_sel;
   } cfg_fields_t;

   function automatic cfg_fields_t split_cfg(input logic [CFG_W-1:0] w);
      cfg_fields_t f;
      f.enable   = w[BIT_EN];
      f.clr_rx   = w[BIT_CLRRX];
      f.clr_tx   = w[BIT_CLRTX];
      f.trig_sel = w[TRIG_LSB +: 2];
      return f;
   endfunction
endpackage

// File: rtl/uftc_cfg.sv
module uftc_cfg
   import uftc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic             en_o,
   output logic [1:0]       trig_sel_o,
   output logic             flush_rx_o,
   output logic             flush_tx_o
);
   cfg_fields_t f;
   logic        en_q;
   logic [1:0]  trig_q;
   logic        toggle;
   logic        unused_rsvd;

   assign f           = split_cfg(wdata);
   assign unused_rsvd = ^wdata[5:3];
   assign toggle      = we && (f.enable != en_q);
   assign flush_rx_o  = toggle || (we && f.enable && f.clr_rx);
   assign flush_tx_o  = toggle || (we && f.enable && f.clr_tx);
   assign en_o        = en_q;
   assign trig_sel_o  = trig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         trig_q <= 2'b00;
      end else if (we) begin
         en_q <= f.enable;
         if (f.enable) trig_q <= f.trig_sel;
      end
   end
endmodule

// File: rtl/uftc_fifo.sv
module uftc_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic [LW-1:0] level,
   output logic          empty,
   output logic          full,
   output logic          overrun
);
   localparam bit POW2 = (DEPTH == (1 << AW));

   generate
      if (DEPTH < 2) begin : g_depth_bad
         $error("uftc_fifo: DEPTH must be at least 2");
      end
      if (DW < 1) begin : g_dw_bad
         $error("uftc_fifo: DW must be at least 1");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [LW-1:0] cnt;
   logic [DW-1:0] dout_q;
   logic          ovr_q;
   logic          do_push, do_pop, drop;

   generate
      if (POW2) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_mod
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign empty   = (cnt == '0);
   assign full    = (cnt == LW'(DEPTH));
   assign do_pop  = en && !flush && pop && !empty;
   assign do_push = en && !flush && push && (!full || do_pop);
   assign drop    = en && !flush && push && !do_push;

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
         ovr_q  <= 1'b0;
         dout_q <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
         ovr_q  <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop) begin
            rd_ptr <= rd_nxt;
            dout_q <= mem[rd_ptr];
         end
         if (drop) ovr_q <= 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign dout    = dout_q;
   assign level   = cnt;
   assign overrun = ovr_q;
endmodule

// File: rtl/uftc_trig.sv
module uftc_trig #(
   parameter int DEPTH  = 16,
   parameter int TRIG_0 = 1,
   parameter int TRIG_1 = 4,
   parameter int TRIG_2 = 8,
   parameter int TRIG_3 = 14,
   localparam int LW    = $clog2(DEPTH + 1)
) (
   input  logic          en,
   input  logic [1:0]    sel,
   input  logic [LW-1:0] level,
   output logic          req
);
   localparam int TBL [4] = '{TRIG_0, TRIG_1, TRIG_2, TRIG_3};

   generate
      for (genvar i = 0; i < 4; i++) begin : g_chk
         if (TBL[i] < 1 || TBL[i] > DEPTH) begin : g_bad
            $error("uftc_trig: threshold out of range 1..DEPTH");
         end
      end
   endgenerate

   logic [LW-1:0] thr;

   always_comb begin
      case (sel)
         2'd0:    thr = LW'(TRIG_0);
         2'd1:    thr = LW'(TRIG_1);
         2'd2:    thr = LW'(TRIG_2);
         default: thr = LW'(TRIG_3);
      endcase
   end

   assign req = en && (level >= thr);
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
   parameter int DEPTH  = 16,
   parameter int DW     = 8,
   parameter int TRIG_0 = 1,
   parameter int TRIG_1 = 4,
   parameter int TRIG_2 = 8,
   parameter int TRIG_3 = 14,
   localparam int LW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [7:0]    cfg_wdata,
   output logic          fifo_en,
   input  logic          rx_push,
   input  logic [DW-1:0] rx_din,
   input  logic          rx_pop,
   output logic [DW-1:0] rx_dout,
   output logic [LW-1:0] rx_level,
   output logic          rx_empty,
   output logic          rx_full,
   output logic          rx_overrun,
   output logic          rx_req,
   input  logic          tx_push,
   input  logic [DW-1:0] tx_din,
   input  logic          tx_pop,
   output logic [DW-1:0] tx_dout,
   output logic [LW-1:0] tx_level,
   output logic          tx_empty,
   output logic          tx_full,
   output logic          tx_overrun
);
   logic       en;
   logic [1:0] trig_sel;
   logic       flush_rx, flush_tx;

   uftc_cfg u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .wdata      (cfg_wdata),
      .en_o       (en),
      .trig_sel_o (trig_sel),
      .flush_rx_o (flush_rx),
      .flush_tx_o (flush_tx)
   );

   uftc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .flush   (flush_rx),
      .push    (rx_push),
      .din     (rx_din),
      .pop     (rx_pop),
      .dout    (rx_dout),
      .level   (rx_level),
      .empty   (rx_empty),
      .full    (rx_full),
      .overrun (rx_overrun)
   );

   uftc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .flush   (flush_tx),
      .push    (tx_push),
      .din     (tx_din),
      .pop     (tx_pop),
      .dout    (tx_dout),
      .level   (tx_level),
      .empty   (tx_empty),
      .full    (tx_full),
      .overrun (tx_overrun)
   );

   uftc_trig #(
      .DEPTH(DEPTH), .TRIG_0(TRIG_0), .TRIG_1(TRIG_1),
      .TRIG_2(TRIG_2), .TRIG_3(TRIG_3)
   ) u_trig (
      .en    (en),
      .sel   (trig_sel),
      .level (rx_level),
      .req   (rx_req)
   );

   assign fifo_en = en;
endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_we,
   input logic          cfg_en_bit,
   input logic          fifo_en,
   input logic          rx_push,
   input logic          rx_pop,
   input logic [DW-1:0] rx_dout,
   input logic [LW-1:0] rx_level,
   input logic          rx_empty,
   input logic          rx_full,
   input logic          rx_overrun,
   input logic          rx_req,
   input logic [LW-1:0] tx_level
);
   // R8: level never exceeds capacity
   assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level <= LW'(DEPTH)) && (tx_level <= LW'(DEPTH)));

   // R3: an enable change leaves both queues empty with no overrun
   assert_toggle_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (cfg_en_bit != fifo_en)) |=>
         (rx_level == '0) && (tx_level == '0) && !rx_overrun);

   // R9: push into a full queue is dropped and flagged
   assert_drop_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && !cfg_we && rx_push && !rx_pop && rx_full) |=>
         rx_overrun && (rx_level == LW'(DEPTH)));

   // R10: pop from empty holds data and level
   assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && !cfg_we && rx_pop && !rx_push && rx_empty) |=>
         $stable(rx_dout) && (rx_level == '0));

   // R11: while disabled and left alone, both queues stay empty
   assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && !cfg_we) |=> (rx_level == '0) && (tx_level == '0));

   // R6: the request only appears with data present while enabled
   assert_req_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_req |-> (fifo_en && (rx_level != '0)));
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_en_bit (cfg_wdata[0]),
   .fifo_en    (fifo_en),
   .rx_push    (rx_push),
   .rx_pop     (rx_pop),
   .rx_dout    (rx_dout),
   .rx_level   (rx_level),
   .rx_empty   (rx_empty),
   .rx_full    (rx_full),
   .rx_overrun (rx_overrun),
   .rx_req     (rx_req),
   .tx_level   (tx_level)
);

// File: tb/uart_fifo_ctl_bench.sv
module uart_fifo_ctl_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic       fifo_en;
   logic       rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
   logic [7:0] rx_din = 8'h00, tx_din = 8'h00;
   logic [7:0] rx_dout, tx_dout;
   logic [4:0] rx_level, tx_level;
   logic       rx_empty, rx_full, rx_overrun, rx_req;
   logic       tx_empty, tx_full, tx_overrun;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   uart_fifo_ctl u_uart_fifo_ctl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .fifo_en(fifo_en),
      .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
      .rx_level(rx_level), .rx_empty(rx_empty), .rx_full(rx_full),
      .rx_overrun(rx_overrun), .rx_req(rx_req),
      .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
      .tx_level(tx_level), .tx_empty(tx_empty), .tx_full(tx_full),
      .tx_overrun(tx_overrun)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic push_rx(input logic [7:0] d);
      @(negedge clk);
      rx_push = 1'b1; rx_din = d;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic pop_rx();
      @(negedge clk);
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
   endtask

   task automatic push_tx(input logic [7:0] d);
      @(negedge clk);
      tx_push = 1'b1; tx_din = d;
      @(negedge clk);
      tx_push = 1'b0;
   endtask

   task automatic pop_tx();
      @(negedge clk);
      tx_pop = 1'b1;
      @(negedge clk);
      tx_pop = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "rx_level", int'(rx_level), 0);
      chk("R1", "tx_level", int'(tx_level), 0);
      chk("R1", "empty flags", int'({rx_empty, tx_empty}), 3);
      chk("R1", "full flags", int'({rx_full, tx_full}), 0);
      chk("R1", "overrun flags", int'({rx_overrun, tx_overrun}), 0);
      chk("R1", "fifo_en", int'(fifo_en), 0);
      chk("R1", "rx_req", int'(rx_req), 0);
   endtask

   task automatic t_enable();
      push_rx(8'h11);
      push_tx(8'h22);
      chk("R11", "rx_level disabled push", int'(rx_level), 0);
      chk("R11", "tx_level disabled push", int'(tx_level), 0);
      pop_rx();
      chk("R11", "rx_dout disabled pop", int'(rx_dout), 0);
      cfg_write(8'h01);
      chk("R2", "fifo_en after enable", int'(fifo_en), 1);
      push_rx(8'h33);
      chk("R2", "rx_level after enabled push", int'(rx_level), 1);
      cfg_write(8'h00);
      chk("R2", "fifo_en after disable", int'(fifo_en), 0);
      cfg_write(8'h01);
   endtask

   task automatic t_order();
      for (int i = 0; i < 5; i++) push_rx(8'hA0 + 8'(i));
      chk("R8", "rx_level after 5 pushes", int'(rx_level), 5);
      for (int i = 0; i < 3; i++) begin
         pop_rx();
         chk("R8", "rx_dout order", int'(rx_dout), 'hA0 + i);
      end
      @(negedge clk);
      rx_push = 1'b1; rx_pop = 1'b1; rx_din = 8'hB5;
      @(negedge clk);
      rx_push = 1'b0; rx_pop = 1'b0;
      chk("R8", "level on push+pop", int'(rx_level), 2);
      chk("R8", "dout on push+pop", int'(rx_dout), 'hA3);
      pop_rx();
      pop_rx();
      chk("R8", "dout after push+pop", int'(rx_dout), 'hB5);
      push_tx(8'h5A);
      pop_tx();
      chk("R8", "tx_dout", int'(tx_dout), 'h5A);
   endtask

   task automatic t_full();
      for (int i = 0; i < 16; i++) push_rx(8'(i));
      chk("R9", "rx_full at 16", int'(rx_full), 1);
      chk("R9", "rx_overrun before drop", int'(rx_overrun), 0);
      push_rx(8'hEE);
      chk("R9", "rx_level after drop", int'(rx_level), 16);
      chk("R9", "rx_overrun after drop", int'(rx_overrun), 1);
      for (int i = 0; i < 16; i++) begin
         pop_rx();
         chk("R9", "stored byte kept", int'(rx_dout), i);
      end
      chk("R9", "overrun sticky", int'(rx_overrun), 1);
   endtask

   task automatic t_empty();
      pop_rx();
      chk("R10", "rx_dout on empty pop", int'(rx_dout), 15);
      chk("R10", "rx_level on empty pop", int'(rx_level), 0);
      cfg_write(8'h03);
      chk("R9", "overrun cleared by flush", int'(rx_overrun), 0);
   endtask

   task automatic t_trigger();
      cfg_write(8'h43);
      for (int i = 0; i < 3; i++) push_rx(8'h10);
      chk("R6", "req at 3 thr 4", int'(rx_req), 0);
      push_rx(8'h10);
      chk("R6", "req at 4 thr 4", int'(rx_req), 1);
      cfg_write(8'h81);
      chk("R6", "level kept on trig change", int'(rx_level), 4);
      chk("R6", "req at 4 thr 8", int'(rx_req), 0);
      for (int i = 0; i < 4; i++) push_rx(8'h10);
      chk("R6", "req at 8 thr 8", int'(rx_req), 1);
      cfg_write(8'hC1);
      chk("R6", "req at 8 thr 14", int'(rx_req), 0);
      for (int i = 0; i < 5; i++) push_rx(8'h10);
      chk("R6", "req at 13 thr 14", int'(rx_req), 0);
      push_rx(8'h10);
      chk("R6", "req at 14 thr 14", int'(rx_req), 1);
      cfg_write(8'h39);
      chk("R7", "level after reserved bits", int'(rx_level), 14);
      chk("R7", "req after reserved bits thr 1", int'(rx_req), 1);
      cfg_write(8'h03);
      chk("R6", "req after flush", int'(rx_req), 0);
      push_rx(8'h10);
      chk("R6", "req at 1 thr 1", int'(rx_req), 1);
   endtask

   task automatic t_clear();
      cfg_write(8'h03);
      for (int i = 0; i < 3; i++) push_rx(8'h40);
      push_tx(8'h61);
      push_tx(8'h62);
      cfg_write(8'h03);
      chk("R4", "rx emptied", int'(rx_level), 0);
      chk("R4", "tx untouched", int'(tx_level), 2);
      push_rx(8'h41);
      cfg_write(8'h01);
      chk("R4", "rx bit not retained", int'(rx_level), 1);
      cfg_write(8'h05);
      chk("R5", "tx emptied", int'(tx_level), 0);
      chk("R5", "rx untouched", int'(rx_level), 1);
      push_tx(8'h63);
      cfg_write(8'h01);
      chk("R5", "tx bit not retained", int'(tx_level), 1);
   endtask

   task automatic t_toggle();
      push_rx(8'h70);
      for (int i = 0; i < 16; i++) push_tx(8'h71);
      chk("R3", "tx overrun set", int'(tx_overrun), 1);
      cfg_write(8'h00);
      chk("R3", "rx flushed on fall", int'(rx_level), 0);
      chk("R3", "tx flushed on fall", int'(tx_level), 0);
      chk("R3", "tx overrun cleared", int'(tx_overrun), 0);
      cfg_write(8'h01);
      push_rx(8'h72);
      cfg_write(8'h00);
      cfg_write(8'h01);
      chk("R3", "rx empty after rise", int'(rx_level), 0);
   endtask

   task automatic t_flush_vs_push();
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = 8'h03; rx_push = 1'b1; rx_din = 8'h90;
      @(negedge clk);
      cfg_we = 1'b0; rx_push = 1'b0;
      chk("R12", "push lost to flush", int'(rx_level), 0);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = 8'h01; rx_push = 1'b1; rx_din = 8'h91;
      @(negedge clk);
      cfg_we = 1'b0; rx_push = 1'b0;
      chk("R12", "push kept with plain write", int'(rx_level), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_order();
      t_full();
      t_empty();
      t_trigger();
      t_clear();
      t_toggle();
      t_flush_vs_push();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule